// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block turns one decoded load or store into the byte-wide bus transactions it needs, along with the register and base-register values that result. It handles two kinds of instruction.

- **Single transfer.** It moves one register or one byte. The offset is applied either before the access or after it, and the base register may be updated.
- **Block transfer.** It moves every register named in a 16-bit list. The start address depends on the list size and on one of four stepping modes.

The memory side is one byte wide. A 32-bit word therefore becomes four consecutive byte transactions. These start at an address whose two low bits are forced to zero, and the lowest address carries the least significant byte.

The surrounding core pulses `start` while the sequencer is idle. On that pulse the core supplies the decoded control bits, the base value, the offset, and either the register list or the single register index. It also supplies register-file read data for the index the sequencer presents on `rd_idx`.

The sequencer has three states:

- **IDLE.** It waits for `start`.
- **MOVE.** It issues one byte per cycle in which `bus_ready` is high.
- **CLOSE.** It lasts one cycle. It pulses `done` and, when the base is to be updated, `base_we`.

The transitions are:

- IDLE→MOVE: on `start` when there is data to move.
- IDLE→CLOSE: on `start` with an empty block list.
- MOVE→MOVE: while bytes or registers remain.
- MOVE→CLOSE: after the last byte of the last register.
- CLOSE→IDLE: always.

Loaded registers are written through `reg_we` in the same cycle as their last byte. Because the base update comes later, in CLOSE, a base update wins over a load into the same register.

Top module: `ldst_addr_seq`

## Requirements
- R1: For a single transfer with `pre_idx`=1, the access address is base+offset when `up`=1 and base−offset when `up`=0.
- R2: For a single transfer with `pre_idx`=0, the access uses the base itself, and the base is then written back as base±offset (+ when `up`=1) regardless of `wback`.
- R3: A single transfer drives `base_we` in CLOSE exactly when `pre_idx`=0 or `wback`=1, and never in any other cycle.
- R4: A single transfer with `byte_mode`=1 performs exactly one bus transaction at the unaligned address. A load writes the byte into bits [7:0] and zeros into bits [31:8]. A store drives bits [7:0] of the source register.
- R5: A word transfer clears address bits [1:0] and performs four transactions at offsets 0,1,2,3. The byte at the lowest address maps to register bits [7:0] and the byte at offset 3 maps to bits [31:24].
- R6: For a block transfer (`multi`=1) with n registers in the list, the first address is chosen by (`pre_idx`,`up`): (0,1) gives base, (1,1) gives base+4, (1,0) gives base−4n, and (0,0) gives base−4n+4. Block transfers always move whole words, and `byte_mode` is ignored.
- R7: A block transfer moves the listed registers in ascending index order, and the address rises by 4 from one register to the next.
- R8: A block transfer with `wback`=1 writes back base+4n when `up`=1 and base−4n when `up`=0. With `wback`=0 there is no base write.
- R9: A block transfer with an empty list makes no bus transactions and no base write, and still pulses `done` once.
- R10: With `base_pc`=1, the base value used in every calculation is `base`+8.
- R11: A bus transaction completes in each cycle in which `bus_req` and `bus_ready` are both high. While `bus_ready` is low, `bus_req` and `bus_addr` hold.
- R12: After reset `busy`=0 and `bus_req`=0. A `start` while busy is ignored. `done` is high for one cycle, after which `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in IDLE only) |
| multi | input | 1 | 1 = block transfer, 0 = single transfer |
| pre_idx | input | 1 | Apply offset / step before the access |
| up | input | 1 | 1 = add, 0 = subtract |
| byte_mode | input | 1 | Single byte transfer |
| wback | input | 1 | Request base writeback |
| load | input | 1 | 1 = load, 0 = store |
| base_pc | input | 1 | Base is the instruction address (add 8) |
| base | input | 32 | Base register value |
| offset | input | 32 | Single-transfer offset |
| reg_list | input | 16 | Block-transfer register list |
| xfer_reg | input | 4 | Single-transfer data register index |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Byte transaction request |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 8 | Write byte |
| bus_ready | input | 1 | Memory accepts this cycle |
| bus_rdata | input | 8 | Read byte, valid when ready |
| rd_idx | output | 4 | Register-file read index for store data |
| rd_data | input | 32 | Register-file read data |
| reg_we | output | 1 | Loaded register write strobe |
| reg_waddr | output | 4 | Loaded register index |
| reg_wdata | output | 32 | Loaded register value |
| base_we | output | 1 | Base writeback strobe |
| base_wdata | output | 32 | New base value |

## Verification
The assertions check four properties on every cycle:

- the request and address hold through a stall;
- a word starts aligned and its beats step by one byte;
- register writes happen only on the final beat of a load;
- base writes and `done` come only in the one-cycle CLOSE state, followed by idle.

The properties that depend on the instruction are shown only by the bench's scenarios, which check the results against a memory and register model. These are the arithmetic of the pre- and post-indexed addresses, the four block-mode start addresses and writeback values, ascending register order, little-endian assembly, zero extension, the PC+8 base, the empty list, and a start pulse ignored while busy.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MOVE  = 2'd1,
        ST_CLOSE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ldst_low_pick.sv
// Finds the lowest set bit of a vector (ascending transfer order).
module ldst_low_pick #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ldst_addr_calc.sv
// First access address and writeback value for one instruction.
module ldst_addr_calc #(
    parameter int AW       = 32,
    parameter int NREGS    = 16,
    parameter int NB       = 4,
    parameter int PC_AHEAD = 8
) (
    input  logic             multi,
    input  logic             pre_idx,
    input  logic             up,
    input  logic             wback,
    input  logic             base_pc,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    offset,
    input  logic [NREGS-1:0] reg_list,
    output logic [AW-1:0]    first_addr,
    output logic [AW-1:0]    wb_value,
    output logic             wb_enable,
    output logic             list_empty
);
    logic [AW-1:0] eff;
    logic [AW-1:0] moved;
    logic [AW-1:0] span;

    always_comb begin
        eff        = base_pc ? base + AW'(PC_AHEAD) : base;
        moved      = up ? eff + offset : eff - offset;
        span       = AW'($countones(reg_list)) * AW'(NB);
        list_empty = (reg_list == '0);
        if (multi) begin
            unique case ({pre_idx, up})
                2'b01:   first_addr = eff;
                2'b11:   first_addr = eff + AW'(NB);
                2'b10:   first_addr = eff - span;
                default: first_addr = eff - span + AW'(NB);
            endcase
            wb_value  = up ? eff + span : eff - span;
            wb_enable = wback && !list_empty;
        end else begin
            first_addr = pre_idx ? moved : eff;
            wb_value   = moved;
            wb_enable  = !pre_idx || wback;
        end
    end
endmodule

// File: rtl/ldst_addr_seq.sv
module ldst_addr_seq
    import ldst_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NREGS = 16,
    localparam int RIW  = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             multi,
    input  logic             pre_idx,
    input  logic             up,
    input  logic             byte_mode,
    input  logic             wback,
    input  logic             load,
    input  logic             base_pc,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    offset,
    input  logic [NREGS-1:0] reg_list,
    input  logic [RIW-1:0]   xfer_reg,
    output logic             busy,
    output logic             done,
    output logic             bus_req,
    output logic             bus_we,
    output logic [AW-1:0]    bus_addr,
    output logic [7:0]       bus_wdata,
    input  logic             bus_ready,
    input  logic [7:0]       bus_rdata,
    output logic [RIW-1:0]   rd_idx,
    input  logic [DW-1:0]    rd_data,
    output logic             reg_we,
    output logic [RIW-1:0]   reg_waddr,
    output logic [DW-1:0]    reg_wdata,
    output logic             base_we,
    output logic [AW-1:0]    base_wdata
);
    localparam int NB = DW / 8;
    localparam int BW = $clog2(NB);

    seq_state_e        state_q;
    logic [AW-1:0]     addr_q;
    logic [BW-1:0]     beat_q;
    logic [DW-9:0]     acc_q;
    logic [NREGS-1:0]  list_q;
    logic [RIW-1:0]    sreg_q;
    logic              multi_q, byte_q, load_q, wbe_q;
    logic [AW-1:0]     wbv_q;

    logic [AW-1:0]     calc_first, calc_wbv;
    logic              calc_wbe, calc_empty;
    logic [RIW-1:0]    low_idx, cur_reg;
    logic              hs, last_beat, last_reg;
    logic [NREGS-1:0]  list_next;

    ldst_addr_calc #(.AW(AW), .NREGS(NREGS), .NB(NB), .PC_AHEAD(8)) u_calc (
        .multi(multi), .pre_idx(pre_idx), .up(up), .wback(wback),
        .base_pc(base_pc), .base(base), .offset(offset), .reg_list(reg_list),
        .first_addr(calc_first), .wb_value(calc_wbv), .wb_enable(calc_wbe),
        .list_empty(calc_empty)
    );

    ldst_low_pick #(.N(NREGS)) u_pick (.vec(list_q), .idx(low_idx));

    always_comb begin
        cur_reg   = multi_q ? low_idx : sreg_q;
        hs        = (state_q == ST_MOVE) && bus_ready;
        last_beat = byte_q || (beat_q == BW'(NB - 1));
        list_next = list_q & ~(NREGS'(1) << cur_reg);
        last_reg  = !multi_q || (list_next == '0);
    end

    // State and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            beat_q  <= '0;
            acc_q   <= '0;
            list_q  <= '0;
            sreg_q  <= '0;
            multi_q <= 1'b0;
            byte_q  <= 1'b0;
            load_q  <= 1'b0;
            wbe_q   <= 1'b0;
            wbv_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        multi_q <= multi;
                        byte_q  <= byte_mode && !multi;
                        load_q  <= load;
                        sreg_q  <= xfer_reg;
                        list_q  <= reg_list;
                        wbe_q   <= calc_wbe;
                        wbv_q   <= calc_wbv;
                        beat_q  <= '0;
                        addr_q  <= (byte_mode && !multi) ? calc_first
                                   : (calc_first & ~AW'(NB - 1));
                        state_q <= (multi && calc_empty) ? ST_CLOSE : ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (hs) begin
                        addr_q <= addr_q + AW'(1);
                        if (last_beat) begin
                            beat_q <= '0;
                            list_q <= list_next;
                            if (last_reg) state_q <= ST_CLOSE;
                        end else begin
                            beat_q <= beat_q + BW'(1);
                            acc_q  <= {bus_rdata, acc_q[DW-9:8]};
                        end
                    end
                end
                ST_CLOSE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_CLOSE);
        bus_req    = (state_q == ST_MOVE);
        bus_we     = bus_req && !load_q;
        bus_addr   = addr_q;
        bus_wdata  = rd_data[{beat_q, 3'b000} +: 8];
        rd_idx     = cur_reg;
        reg_we     = hs && last_beat && load_q;
        reg_waddr  = cur_reg;
        reg_wdata  = byte_q ? {{(DW-8){1'b0}}, bus_rdata} : {bus_rdata, acc_q};
        base_we    = done && wbe_q;
        base_wdata = wbv_q;
    end
endmodule

// File: rtl/ldst_addr_seq_chk.sv
module ldst_addr_seq_chk #(
    parameter int AW = 32,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_ready,
    input logic [AW-1:0] bus_addr,
    input logic          byte_q,
    input logic          load_q,
    input logic [BW-1:0] beat_q,
    input logic          reg_we,
    input logic          base_we,
    input logic          done,
    input logic          busy
);
    a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)));

    a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && !byte_q && beat_q != '1)
        |=> (bus_req && bus_addr == $past(bus_addr) + AW'(1)));

    a_r5_aligned_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !byte_q && beat_q == '0) |-> (bus_addr[1:0] == 2'b00));

    a_r4_regwrite_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (load_q && bus_req && bus_ready));

    a_r3_wb_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> (done && !bus_req));

    a_r12_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind ldst_addr_seq ldst_addr_seq_chk #(.AW(AW), .BW($clog2(DW / 8))) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .byte_q(byte_q), .load_q(load_q), .beat_q(beat_q),
    .reg_we(reg_we), .base_we(base_we), .done(done), .busy(busy)
);

// File: tb/tb_ldst_addr_seq.sv
`timescale 1ns/1ps
module tb_ldst_addr_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 0, multi = 0, pre_idx = 0, up = 0, byte_mode = 0;
    logic        wback = 0, load = 0, base_pc = 0;
    logic [31:0] base = 0, offset = 0;
    logic [15:0] reg_list = 0;
    logic [3:0]  xfer_reg = 0;
    logic        busy, done, bus_req, bus_we, reg_we, base_we;
    logic [31:0] bus_addr, reg_wdata, base_wdata, rd_data;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        bus_ready = 1'b1;
    logic [3:0]  rd_idx, reg_waddr;

    ldst_addr_seq dut (.*);

    logic [7:0]  mem [256];
    logic [31:0] regs [16];
    logic [31:0] trace [64];
    int          ntr, ndone, nwb, nvec, nfail, cyc;
    logic [31:0] wbv;
    logic        stall_mode = 0;

    assign bus_rdata = mem[bus_addr[7:0]];
    assign rd_data   = regs[rd_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_req && bus_ready) begin
            if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
            if (ntr < 64) trace[ntr] <= bus_addr;
            ntr <= ntr + 1;
        end
        if (reg_we) regs[reg_waddr] <= reg_wdata;
        if (base_we) begin nwb <= nwb + 1; wbv <= base_wdata; end
        if (done) ndone <= ndone + 1;
    end

    always @(negedge clk) bus_ready <= stall_mode ? ~bus_ready : 1'b1;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction
    function automatic logic [31:0] wordat(input int a);
        return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask
    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic prep();
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 * i + 32'h0102_0304 * (i + 1);
        ntr = 0; ndone = 0; nwb = 0; wbv = 'x;
    endtask

    task automatic setup(input bit m, input bit p, input bit u, input bit b, input bit w,
                         input bit l, input bit pc, input logic [31:0] bs, input logic [31:0] off,
                         input logic [15:0] lst, input logic [3:0] r);
        multi = m; pre_idx = p; up = u; byte_mode = b; wback = w; load = l; base_pc = pc;
        base = bs; offset = off; reg_list = lst; xfer_reg = r;
    endtask

    task automatic fire();
        start = 1;
        @(negedge clk);
        start = 0;
        for (int t = 0; t < 200 && ndone == 0; t++) @(negedge clk);
        @(negedge clk);
        if (ndone == 0) chk(0, "timeout", 0, 1);
    endtask

    // R1 R5: pre-index up, word load, no writeback
    task automatic t_pre_up_word();
        prep();
        setup(0, 1, 1, 0, 0, 1, 0, 32'h40, 32'h10, 0, 4'd3);
        fire();
        chk_eq("R1 first addr", trace[0], 32'h50);
        chk_eq("R5 last byte addr", trace[3], 32'h53);
        chk_eq("R5 count", ntr, 4);
        chk_eq("R5 little-endian value", regs[3], wordat(32'h50));
        chk_eq("R3 no wb", nwb, 0);
    endtask

    // R1 R4 R3: pre-index down, byte load, W=1
    task automatic t_pre_down_byte();
        prep();
        setup(0, 1, 0, 1, 1, 1, 0, 32'h40, 32'h3, 0, 4'd5);
        fire();
        chk_eq("R4 single txn", ntr, 1);
        chk_eq("R1 down addr", trace[0], 32'h3D);
        chk_eq("R4 zero extend", regs[5], {24'h0, pat(32'h3D)});
        chk_eq("R3 wb value", wbv, 32'h3D);
        chk_eq("R3 wb count", nwb, 1);
    endtask

    // R2 R5: post-index up word store, forced writeback
    task automatic t_post_store();
        prep();
        regs[2] = 32'h1122_3344;
        setup(0, 0, 1, 0, 0, 0, 0, 32'h20, 32'h8, 0, 4'd2);
        fire();
        chk_eq("R2 access at base", trace[0], 32'h20);
        chk_eq("R5 store bytes", {mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]}, 32'h1122_3344);
        chk_eq("R2 wb base+off", wbv, 32'h28);
    endtask

    // R5: unaligned word address forced aligned
    task automatic t_unaligned_word();
        prep();
        setup(0, 1, 1, 0, 0, 1, 0, 32'h47, 32'h0, 0, 4'd7);
        fire();
        chk_eq("R5 aligned start", trace[0], 32'h44);
        chk_eq("R5 aligned value", regs[7], wordat(32'h44));
    endtask

    // R4 R2: post-index down byte store
    task automatic t_byte_store();
        prep();
        regs[6] = 32'hDEAD_BE5A;
        setup(0, 0, 0, 1, 0, 0, 0, 32'h31, 32'h1, 0, 4'd6);
        fire();
        chk_eq("R4 byte stored", mem[8'h31], 8'h5A);
        chk_eq("R4 neighbour kept", mem[8'h32], pat(32'h32));
        chk_eq("R2 wb base-off", wbv, 32'h30);
    endtask

    // R10: PC-relative base
    task automatic t_pc_base();
        prep();
        setup(0, 1, 1, 1, 0, 1, 1, 32'h60, 32'h4, 0, 4'd1);
        fire();
        chk_eq("R10 pc+8+off", trace[0], 32'h6C);
        chk_eq("R10 value", regs[1], {24'h0, pat(32'h6C)});
    endtask

    // R6 R7 R8: increment-after load, writeback
    task automatic t_ia_load();
        prep();
        setup(1, 0, 1, 1, 1, 1, 0, 32'h80, 0, 16'b0000_0000_0010_1010, 0);
        fire();
        chk_eq("R6 IA start", trace[0], 32'h80);
        chk_eq("R7 step", trace[4], 32'h84);
        chk_eq("R6 byte_mode ignored count", ntr, 12);
        chk_eq("R7 r1", regs[1], wordat(32'h80));
        chk_eq("R7 r3", regs[3], wordat(32'h84));
        chk_eq("R7 r5", regs[5], wordat(32'h88));
        chk_eq("R8 wb up", wbv, 32'h8C);
    endtask

    // R6 R8: increment-before store, no writeback
    task automatic t_ib_store();
        prep();
        setup(1, 1, 1, 0, 0, 0, 0, 32'h90, 0, 16'b0101, 0);
        fire();
        chk_eq("R6 IB start", trace[0], 32'h94);
        chk_eq("R7 r0 at 94", wordat(0) ^ wordat(0) ^ {mem[8'h97], mem[8'h96], mem[8'h95], mem[8'h94]}, regs[0]);
        chk_eq("R7 r2 at 98", {mem[8'h9B], mem[8'h9A], mem[8'h99], mem[8'h98]}, regs[2]);
        chk_eq("R8 no wb", nwb, 0);
    endtask

    // R6 R8: decrement-before load
    task automatic t_db_load();
        prep();
        setup(1, 1, 0, 0, 1, 1, 0, 32'hC0, 0, 16'b1101_0000, 0);
        fire();
        chk_eq("R6 DB start", trace[0], 32'hB4);
        chk_eq("R7 r4", regs[4], wordat(32'hB4));
        chk_eq("R7 r7", regs[7], wordat(32'hBC));
        chk_eq("R8 wb down", wbv, 32'hB4);
    endtask

    // R6 R7: decrement-after store
    task automatic t_da_store();
        prep();
        setup(1, 0, 0, 0, 1, 0, 0, 32'hD0, 0, 16'h8100, 0);
        fire();
        chk_eq("R6 DA start", trace[0], 32'hCC);
        chk_eq("R7 r8 at CC", {mem[8'hCF], mem[8'hCE], mem[8'hCD], mem[8'hCC]}, regs[8]);
        chk_eq("R7 r15 at D0", {mem[8'hD3], mem[8'hD2], mem[8'hD1], mem[8'hD0]}, regs[15]);
        chk_eq("R8 wb DA", wbv, 32'hC8);
    endtask

    // R9: empty list
    task automatic t_empty();
        prep();
        setup(1, 0, 1, 0, 1, 1, 0, 32'h80, 0, 16'h0, 0);
        fire();
        chk_eq("R9 no txn", ntr, 0);
        chk_eq("R9 no wb", nwb, 0);
        chk_eq("R9 one done", ndone, 1);
    endtask

    // R11: alternating ready
    task automatic t_stall();
        prep();
        stall_mode = 1;
        setup(1, 0, 1, 0, 0, 1, 0, 32'h40, 0, 16'h0200, 0);
        fire();
        stall_mode = 0;
        chk_eq("R11 txn count under stall", ntr, 4);
        chk_eq("R11 order", trace[2], 32'h42);
        chk_eq("R11 value", regs[9], wordat(32'h40));
    endtask

    // R12: start while busy ignored
    task automatic t_busy_start();
        prep();
        setup(0, 1, 1, 0, 0, 1, 0, 32'h10, 0, 0, 4'd4);
        start = 1;
        @(negedge clk);
        setup(1, 0, 1, 0, 1, 1, 0, 32'h80, 0, 16'hFFFF, 0);
        chk_eq("R12 busy", busy, 1);
        @(negedge clk);
        start = 0;
        for (int t = 0; t < 50; t++) @(negedge clk);
        chk_eq("R12 single done", ndone, 1);
        chk_eq("R12 txn count", ntr, 4);
        chk_eq("R12 idle after", busy, 0);
        chk_eq("R12 result", regs[4], wordat(32'h10));
    endtask

    initial begin
        cyc = 0; nvec = 0; nfail = 0; ntr = 0; ndone = 0; nwb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_eq("R12 reset busy", busy, 0);
        chk_eq("R12 reset req", bus_req, 0);
        t_pre_up_word();
        t_pre_down_byte();
        t_post_store();
        t_unaligned_word();
        t_byte_store();
        t_pc_base();
        t_ia_load();
        t_ib_store();
        t_db_load();
        t_da_store();
        t_empty();
        t_stall();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #500000;
        nvec++; nfail++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule